// File: doc/BRIEF.md
# PLL Configuration Guard Controller

This block is the digital supervisor of a frequency-multiplying PLL. It keeps the enable state of four reference oscillators, holds the reference selection and the integer multiplication factor, and runs the PLL bring-up order. The analog parts stay outside. It takes a per-source stability flag and a lock flag from them, and drives a per-source enable and a PLL enable back to them.

Software-side logic issues one-cycle request pulses. These requests write a configuration, switch a reference on or off, and turn the PLL on or off. The guard rejects any request that would upset a running PLL. It raises a ready flag only while the PLL output can be used. It also reports the nominal output frequency in kHz, which equals the reference frequency times the factor.

Top module: `pll_cfg_guard`

## Requirements
- R1: After reset, `state` is 0 (idle), `pll_en` and `pll_ready` are 0, `ref_en` is 0, `cur_src` is 0 and `cur_fac` is 1.
- R2: A `cfg_wr` pulse while `pll_en` is 0 stores `cfg_src` into `cur_src` and a non-zero `cfg_fac` (1 to 31) into `cur_fac`, visible one cycle later.
- R3: A write with `cfg_fac` equal to 0 leaves `cur_fac` unchanged, but still takes `cfg_src`.
- R4: While `pll_en` is 1, `cfg_wr` changes neither `cur_src` nor `cur_fac`.
- R5: State codes are 0 idle, 1 waiting for the reference, 2 locking and 3 ready. A `pll_on_req` in idle goes to state 2 (`pll_en`=1) on the next cycle when the selected reference is both enabled and stable.
- R6: Otherwise, a `pll_on_req` in idle goes to state 1 with `pll_en` held at 0. The block leaves state 1 for state 2 one cycle after the selected reference is both enabled and stable.
- R7: `pll_ready` rises one cycle after `pll_locked` and the selected `ref_stable` bit are seen high together in state 2.
- R8: In state 3, a low `pll_locked` or a low selected `ref_stable` returns the block to state 2 and clears `pll_ready` on the next cycle.
- R9: A `ref_on_req[i]` pulse sets `ref_en[i]` and a `ref_off_req[i]` pulse clears it. The one exception: while `pll_en` is 1, a clear of the selected source (`i == cur_src`) is refused.
- R10: A `pll_off_req` returns the block to state 0 with `pll_en` cleared on the next cycle, from any state. It takes priority over a `pll_on_req` in the same cycle.
- R11: `out_freq_khz` equals `cur_fac` times the reference frequency. The source codes give 0 = 2000 kHz, 1 = 8000 kHz (32 MHz divided by 4), 2 = `XTAL_KHZ` and 3 = `EXT_KHZ`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write pulse |
| cfg_src | input | 2 | Reference selection to write |
| cfg_fac | input | FAC_W | Multiplication factor to write |
| pll_on_req | input | 1 | Request to enable the PLL |
| pll_off_req | input | 1 | Request to disable the PLL |
| ref_on_req | input | 4 | Per-source reference enable pulses |
| ref_off_req | input | 4 | Per-source reference disable pulses |
| ref_stable | input | 4 | Per-source reference stable flags |
| pll_locked | input | 1 | PLL lock flag |
| ref_en | output | 4 | Reference enables |
| pll_en | output | 1 | PLL enable |
| pll_ready | output | 1 | PLL output usable |
| state | output | 2 | Controller state code |
| cur_src | output | 2 | Selected reference |
| cur_fac | output | FAC_W | Active multiplication factor |
| out_freq_khz | output | FREQ_W | Nominal output frequency in kHz |

## Verification
The hardest situation to reach is a running PLL that loses lock or reference stability. Both of those are driven by the analog model rather than by requests. The bench's lock model raises `pll_locked` a fixed delay after it sees `pll_en`. A separate kill flag can drop lock at will, and the bench lowers the selected `ref_stable` bit directly while in the ready state. These inputs let the bench step READY back to LOCKING and forward again. The refused-reference case is exercised while the PLL is ready, with the selected source and an unselected one sent off in turn.

// File: rtl/pll_cfg_guard.sv
module pll_cfg_guard #(
  parameter int FAC_W    = 5,
  parameter int FREQ_W   = 20,
  parameter int XTAL_KHZ = 16000,
  parameter int EXT_KHZ  = 12000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_src,
  input  logic [FAC_W-1:0]  cfg_fac,
  input  logic              pll_on_req,
  input  logic              pll_off_req,
  input  logic [3:0]        ref_on_req,
  input  logic [3:0]        ref_off_req,
  input  logic [3:0]        ref_stable,
  input  logic              pll_locked,
  output logic [3:0]        ref_en,
  output logic              pll_en,
  output logic              pll_ready,
  output logic [1:0]        state,
  output logic [1:0]        cur_src,
  output logic [FAC_W-1:0]  cur_fac,
  output logic [FREQ_W-1:0] out_freq_khz
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_LOCK, S_RDY} st_t;
  st_t st, st_nx;

  logic       sel_ok;
  logic [3:0] ref_guard;

  assign sel_ok    = ref_en[cur_src] & ref_stable[cur_src];
  assign pll_en    = (st == S_LOCK) || (st == S_RDY);
  assign pll_ready = (st == S_RDY);
  assign state     = st;
  assign ref_guard = pll_en ? (4'b0001 << cur_src) : 4'b0000;

  always_comb begin
    st_nx = st;
    if (pll_off_req) st_nx = S_IDLE;
    else begin
      case (st)
        S_IDLE: if (pll_on_req) st_nx = sel_ok ? S_LOCK : S_WAIT;
        S_WAIT: if (sel_ok) st_nx = S_LOCK;
        S_LOCK: if (pll_locked && ref_stable[cur_src]) st_nx = S_RDY;
        S_RDY:  if (!pll_locked || !ref_stable[cur_src]) st_nx = S_LOCK;
        default: st_nx = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ref_en  <= '0;
      cur_src <= '0;
      cur_fac <= FAC_W'(1);
    end else begin
      st     <= st_nx;
      ref_en <= (ref_en | ref_on_req) & ~(ref_off_req & ~ref_guard);
      if (cfg_wr && !pll_en) begin
        cur_src <= cfg_src;
        if (cfg_fac != '0) cur_fac <= cfg_fac;
      end
    end
  end

  function automatic logic [FREQ_W-1:0] ref_khz(input logic [1:0] s);
    case (s)
      2'd0:    return FREQ_W'(2000);
      2'd1:    return FREQ_W'(8000);
      2'd2:    return FREQ_W'(XTAL_KHZ);
      default: return FREQ_W'(EXT_KHZ);
    endcase
  endfunction

  assign out_freq_khz = ref_khz(cur_src) * {{(FREQ_W-FAC_W){1'b0}}, cur_fac};
endmodule

// File: rtl/pll_cfg_guard_chk.sv
module pll_cfg_guard_chk #(
  parameter int FAC_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pll_on_req,
  input logic             pll_off_req,
  input logic [3:0]       ref_stable,
  input logic             pll_locked,
  input logic [3:0]       ref_en,
  input logic             pll_en,
  input logic             pll_ready,
  input logic [1:0]       state,
  input logic [1:0]       cur_src,
  input logic [FAC_W-1:0] cur_fac
);
  // R4
  fac_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_en |=> $stable(cur_fac) && $stable(cur_src));
  // R9
  ref_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_en |=> ref_en[$past(cur_src)]);
  // R3
  fac_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_fac != '0);
  // R7
  ready_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_ready |-> pll_en);
  // R7
  ready_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_ready) |-> $past(pll_locked) && $past(state) == 2'd2);
  // R10
  off_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_off_req |=> !pll_en && state == 2'd0);
  // R5
  on_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0 && pll_on_req && !pll_off_req && ref_en[cur_src] && ref_stable[cur_src])
      |=> pll_en);
endmodule

bind pll_cfg_guard pll_cfg_guard_chk #(.FAC_W(FAC_W)) chk_i (.*);

// File: tb/pll_cfg_guard_tb_top.sv
`timescale 1ns/1ps
module pll_cfg_guard_tb_top;
  localparam int FAC_W = 5, FREQ_W = 20, XTAL = 16000, EXT = 12000, LOCK_DLY = 5;

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, pll_on_req = 0, pll_off_req = 0, pll_locked;
  logic [1:0] cfg_src = 0;
  logic [FAC_W-1:0] cfg_fac = 0;
  logic [3:0] ref_on_req = 0, ref_off_req = 0, ref_stable = 0;
  logic [3:0] ref_en; logic pll_en, pll_ready; logic [1:0] state, cur_src;
  logic [FAC_W-1:0] cur_fac; logic [FREQ_W-1:0] out_freq_khz;

  int checks = 0, errors = 0, lock_cnt = 0, cyc = 0;
  logic lock_raw = 0, kill_lock = 0, done = 0;
  assign pll_locked = lock_raw & ~kill_lock;

  int m_state = 0, m_src = 0, m_fac = 1; logic [3:0] m_ref = 0;

  always #2.5 clk = ~clk;

  pll_cfg_guard #(.FAC_W(FAC_W), .FREQ_W(FREQ_W), .XTAL_KHZ(XTAL), .EXT_KHZ(EXT)) dut_i (.*);

  function automatic int khz(int s);
    if (s == 0) return 2000;
    if (s == 1) return 8000;
    if (s == 2) return XTAL;
    return EXT;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_src = 0; m_fac = 1; m_ref = 0;
    end else begin
      automatic int ps = m_state;
      automatic int psrc = m_src;
      automatic bit running = (ps >= 2);
      automatic bit ok = m_ref[psrc] && ref_stable[psrc];
      for (int i = 0; i < 4; i++) begin
        if (ref_on_req[i]) m_ref[i] = 1'b1;
        if (ref_off_req[i] && !(running && i == psrc)) m_ref[i] = 1'b0;
      end
      if (cfg_wr && !running) begin
        m_src = cfg_src;
        if (cfg_fac != 0) m_fac = cfg_fac;
      end
      if (pll_off_req) m_state = 0;
      else if (ps == 0 && pll_on_req) m_state = ok ? 2 : 1;
      else if (ps == 1 && ok) m_state = 2;
      else if (ps == 2 && pll_locked && ref_stable[psrc]) m_state = 3;
      else if (ps == 3 && !(pll_locked && ref_stable[psrc])) m_state = 2;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      chk("R6 state", state, m_state);
      chk("R5 pll_en", pll_en, m_state >= 2);
      chk("R7 pll_ready", pll_ready, m_state == 3);
      chk("R9 ref_en", ref_en, m_ref);
      chk("R2 cur_src", cur_src, m_src);
      chk("R3 cur_fac", cur_fac, m_fac);
      chk("R11 out_freq_khz", out_freq_khz, khz(m_src) * m_fac);
    end
    if (!pll_en) begin lock_cnt = 0; lock_raw = 0; end
    else begin
      if (lock_cnt < LOCK_DLY) lock_cnt++;
      lock_raw = (lock_cnt >= LOCK_DLY);
    end
    if (cyc > 20000 && !done) begin
      done = 1; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(int s, int f);
    cfg_wr = 1; cfg_src = 2'(s); cfg_fac = FAC_W'(f); tick(); cfg_wr = 0;
  endtask

  initial begin
    tick(2);
    chk("R1 state", state, 0); chk("R1 ref_en", ref_en, 0);
    chk("R1 pll_en", pll_en, 0); chk("R1 ready", pll_ready, 0);
    rst_n = 1; tick();
    chk("R1 fac", cur_fac, 1); chk("R1 src", cur_src, 0);

    write_cfg(1, 10);
    chk("R2 fac", cur_fac, 10); chk("R11 freq", out_freq_khz, 80000);
    write_cfg(2, 0);
    chk("R3 fac kept", cur_fac, 10); chk("R3 src taken", cur_src, 2);

    ref_on_req = 4'hF; tick(); ref_on_req = 0;
    pll_on_req = 1; tick(); pll_on_req = 0;
    chk("R6 pending", state, 1); chk("R6 pll_en low", pll_en, 0);
    tick(3);
    chk("R6 still pending", state, 1);
    ref_stable = 4'b0100; tick();
    chk("R6 start locking", state, 2);
    tick(LOCK_DLY + 2);
    chk("R7 ready", pll_ready, 1);

    write_cfg(3, 31);
    chk("R4 fac frozen", cur_fac, 10); chk("R4 src frozen", cur_src, 2);
    ref_off_req = 4'b0100; tick(); ref_off_req = 0;
    chk("R9 selected kept", ref_en[2], 1);
    ref_off_req = 4'b0001; tick(); ref_off_req = 0;
    chk("R9 other cleared", ref_en[0], 0);

    kill_lock = 1; tick();
    chk("R8 lock lost", state, 2); chk("R8 ready low", pll_ready, 0);
    kill_lock = 0; tick(2);
    chk("R7 relock", pll_ready, 1);
    ref_stable = 4'b0000; tick();
    chk("R8 ref unstable", state, 2);
    ref_stable = 4'b0100; tick(2);
    chk("R7 ready again", pll_ready, 1);

    pll_off_req = 1; pll_on_req = 1; tick(); pll_off_req = 0; pll_on_req = 0;
    chk("R10 idle", state, 0); chk("R10 pll_en", pll_en, 0);
    ref_off_req = 4'b0100; tick(); ref_off_req = 0;
    chk("R9 off allowed idle", ref_en[2], 0);

    write_cfg(3, 31);
    chk("R11 ext freq", out_freq_khz, 31 * EXT);
    write_cfg(0, 1);
    chk("R11 min freq", out_freq_khz, 2000);
    ref_stable = 4'b0001;
    pll_on_req = 1; tick(); pll_on_req = 0;
    chk("R6 ref disabled waits", state, 1);
    ref_on_req = 4'b0001; tick(); ref_on_req = 0;
    tick();
    chk("R6 proceeds", state, 2);
    pll_off_req = 1; tick(); pll_off_req = 0;
    ref_on_req = 4'b0001; tick(); ref_on_req = 0;
    pll_on_req = 1; tick(); pll_on_req = 0;
    chk("R5 direct lock", state, 2);
    tick(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule